// File: doc/BRIEF.md
# Two-Level Preemptive Interrupt Controller

This block decides when a small 16-bit processor core leaves its instruction stream to serve an interrupt. It takes two active-low request lines, one high and one low priority, and an active-low power-on preset. It keeps one in-service bit for each level, applies the nesting rules, and gives the core a one-cycle take pulse with the address to continue from. In the same cycle it drives an active-low poll strobe so that the core's polling logic can find which peripheral raised the request.

The high level may interrupt a low-level service that is already running. The low level never preempts: it waits until neither level is in service. While the preset is held low the core is kept stopped and all in-service state is cleared. When the preset is released the block issues a start pulse carrying the start address 0x20. All three inputs pass through two-flop synchronisers. Requests are only acted on in a cycle where the core marks an instruction boundary. A return-from-interrupt strobe closes the most recent service, which is the high level if it is active. A preempted low-level service then carries on.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While rst_ni is low: run_o=0, take_o=0, poll_no=1, isr_hi_o=0, isr_lo_o=0.
- R2: por_ni is synchronised by two flops. From the third rising edge after it goes low, run_o=0 and both in-service bits are 0. While it stays low, no request produces take_o.
- R3: On the third rising edge after por_ni returns high, take_o pulses for exactly one cycle with vec_o=START_ADDR (default 0x0020) and run_o=1. poll_no stays 1 during this start pulse.
- R4: Request inputs are synchronised by two flops and sampled only while boundary_i=1. A request driven low with boundary_i high produces take_o on the third rising edge, not earlier. With boundary_i low it produces nothing.
- R5: A granted high-level request gives take_o=1 for one cycle with vec_o=HI_VEC (default 0x0008) and poll_no=0 in that same cycle only. isr_hi_o is set.
- R6: A low-level request is granted only when neither level is in service and no high request is pending. The grant gives vec_o=LO_VEC (default 0x0004) and poll_no=0, and sets isr_lo_o.
- R7: A high-level request preempts a low-level service in progress: isr_hi_o becomes 1 while isr_lo_o stays 1.
- R8: A low-level request never preempts any service. A high-level request is not taken again while isr_hi_o=1. When both requests arrive together from idle, the high level wins.
- R9: iret_i clears isr_hi_o if it is set, otherwise isr_lo_o. A preempted low-level service stays in service after the high level returns.
- R10: No request is granted in a cycle where iret_i=1. iret_i with nothing in service leaves both bits at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| por_ni | input | 1 | Active-low power-on preset, asynchronous to clk_i |
| irq_hi_ni | input | 1 | Active-low high-priority request |
| irq_lo_ni | input | 1 | Active-low low-priority request |
| boundary_i | input | 1 | Core is at an instruction boundary |
| iret_i | input | 1 | Return-from-interrupt strobe |
| run_o | output | 1 | Core may execute |
| take_o | output | 1 | One-cycle pulse: continue at vec_o |
| vec_o | output | VEC_W | Start or interrupt address |
| poll_no | output | 1 | Active-low interrupt poll strobe |
| isr_hi_o | output | 1 | High level in service |
| isr_lo_o | output | 1 | Low level in service |

## Verification
The bench drives high requests over a running low service and expects nesting. A design without preemption would leave isr_hi_o at 0 there. It also drives low requests over a running high service and from behind a pending high request, where a design that let the low level in would set isr_lo_o too early. It closes services in order and expects a preempted low service to survive the high return. A controller that cleared both bits, or the wrong one, would fail that check. Further tests cover a return coinciding with a boundary, which must not re-grant a stale synchronised request; a preset held during active service, which must clear it and block requests; and the exact edge of the start pulse with its 0x20 address and no poll strobe.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  typedef enum logic [1:0] {
    GNT_NONE  = 2'd0,
    GNT_HI    = 2'd1,
    GNT_LO    = 2'd2,
    GNT_START = 2'd3
  } grant_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import prio_irq_pkg::*;
(
  input  logic   por_req_i,
  input  logic   por_prev_i,
  input  logic   hi_req_i,
  input  logic   lo_req_i,
  input  logic   boundary_i,
  input  logic   iret_i,
  input  logic   isr_hi_i,
  input  logic   isr_lo_i,
  output grant_e grant_o
);
  logic sample_ok;
  logic hi_ok;
  logic lo_ok;

  // requests only at a boundary, never while a return is retiring or start is issued
  assign sample_ok = boundary_i && !iret_i && !por_req_i && !por_prev_i;
  assign hi_ok     = sample_ok && hi_req_i && !isr_hi_i;
  assign lo_ok     = sample_ok && lo_req_i && !hi_req_i && !isr_hi_i && !isr_lo_i;

  always_comb begin
    grant_o = GNT_NONE;
    if (por_prev_i && !por_req_i) grant_o = GNT_START;
    else if (hi_ok)               grant_o = GNT_HI;
    else if (lo_ok)               grant_o = GNT_LO;
  end
endmodule

// File: rtl/irq_inservice.sv
module irq_inservice
  import prio_irq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   por_req_i,
  input  logic   iret_i,
  input  grant_e grant_i,
  output logic   isr_hi_o,
  output logic   isr_lo_o
);
  logic hi_d, lo_d;

  always_comb begin
    hi_d = isr_hi_o;
    lo_d = isr_lo_o;
    if (por_req_i) begin
      hi_d = 1'b0;
      lo_d = 1'b0;
    end else begin
      if (iret_i) begin
        if (isr_hi_o) hi_d = 1'b0;
        else          lo_d = 1'b0;
      end
      if (grant_i == GNT_HI) hi_d = 1'b1;
      if (grant_i == GNT_LO) lo_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_hi_o <= 1'b0;
      isr_lo_o <= 1'b0;
    end else begin
      isr_hi_o <= hi_d;
      isr_lo_o <= lo_d;
    end
  end
endmodule

// File: rtl/irq_resp.sv
module irq_resp
  import prio_irq_pkg::*;
#(
  parameter int unsigned VEC_W      = 16,
  parameter logic [VEC_W-1:0] START_ADDR = 16'h0020,
  parameter logic [VEC_W-1:0] HI_VEC     = 16'h0008,
  parameter logic [VEC_W-1:0] LO_VEC     = 16'h0004
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             por_req_i,
  input  grant_e           grant_i,
  output logic             run_o,
  output logic             take_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             poll_no
);
  logic [VEC_W-1:0] vec_d;

  always_comb begin
    unique case (grant_i)
      GNT_HI:    vec_d = HI_VEC;
      GNT_LO:    vec_d = LO_VEC;
      GNT_START: vec_d = START_ADDR;
      default:   vec_d = vec_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o   <= 1'b0;
      take_o  <= 1'b0;
      vec_o   <= START_ADDR;
      poll_no <= 1'b1;
    end else begin
      run_o   <= !por_req_i;
      take_o  <= (grant_i != GNT_NONE);
      vec_o   <= vec_d;
      poll_no <= !(grant_i == GNT_HI || grant_i == GNT_LO);
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int unsigned VEC_W      = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [VEC_W-1:0] START_ADDR = 16'h0020,
  parameter logic [VEC_W-1:0] HI_VEC     = 16'h0008,
  parameter logic [VEC_W-1:0] LO_VEC     = 16'h0004
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             por_ni,
  input  logic             irq_hi_ni,
  input  logic             irq_lo_ni,
  input  logic             boundary_i,
  input  logic             iret_i,
  output logic             run_o,
  output logic             take_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             poll_no,
  output logic             isr_hi_o,
  output logic             isr_lo_o
);
  localparam int unsigned NLINES = 3;
  localparam logic [NLINES-1:0] SYNC_RST = 3'b110; // preset held, requests idle

  logic [NLINES-1:0] raw_n, sync_n;
  logic   por_req, por_prev, hi_req, lo_req;
  grant_e grant;

  assign raw_n = {irq_hi_ni, irq_lo_ni, por_ni};

  irq_sync #(.W(NLINES), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_n),
    .q_o   (sync_n)
  );

  assign por_req = !sync_n[0];
  assign lo_req  = !sync_n[1];
  assign hi_req  = !sync_n[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) por_prev <= 1'b1;
    else         por_prev <= por_req;
  end

  irq_arbiter u_arb (
    .por_req_i (por_req),
    .por_prev_i(por_prev),
    .hi_req_i  (hi_req),
    .lo_req_i  (lo_req),
    .boundary_i(boundary_i),
    .iret_i    (iret_i),
    .isr_hi_i  (isr_hi_o),
    .isr_lo_i  (isr_lo_o),
    .grant_o   (grant)
  );

  irq_inservice u_isr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .por_req_i(por_req),
    .iret_i   (iret_i),
    .grant_i  (grant),
    .isr_hi_o (isr_hi_o),
    .isr_lo_o (isr_lo_o)
  );

  irq_resp #(
    .VEC_W(VEC_W), .START_ADDR(START_ADDR), .HI_VEC(HI_VEC), .LO_VEC(LO_VEC)
  ) u_resp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .por_req_i(por_req),
    .grant_i  (grant),
    .run_o    (run_o),
    .take_o   (take_o),
    .vec_o    (vec_o),
    .poll_no  (poll_no)
  );
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int unsigned VEC_W = 16,
  parameter logic [VEC_W-1:0] START_ADDR = 16'h0020
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             por_req,
  input logic             iret_i,
  input logic             run_o,
  input logic             take_o,
  input logic [VEC_W-1:0] vec_o,
  input logic             poll_no,
  input logic             isr_hi_o,
  input logic             isr_lo_o
);
  assert_poll_in_take_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !poll_no |-> take_o);

  assert_take_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !take_o);

  assert_halt_no_take_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_o |-> (!take_o && poll_no));

  assert_start_vec_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_o) |-> (take_o && poll_no && vec_o == START_ADDR));

  assert_lo_no_preempt_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(isr_lo_o) |-> $past(!isr_hi_o && !isr_lo_o));

  assert_iret_hi_first_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iret_i && isr_hi_o) |=> !isr_hi_o);

  assert_iret_keeps_lo_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iret_i && isr_hi_o && isr_lo_o && !por_req) |=> isr_lo_o);
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.VEC_W(VEC_W), .START_ADDR(START_ADDR)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .por_req (por_req),
  .iret_i  (iret_i),
  .run_o   (run_o),
  .take_o  (take_o),
  .vec_o   (vec_o),
  .poll_no (poll_no),
  .isr_hi_o(isr_hi_o),
  .isr_lo_o(isr_lo_o)
);

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
  localparam int CLK_P = 10;
  localparam logic [15:0] START = 16'h0020;
  localparam logic [15:0] HIV   = 16'h0008;
  localparam logic [15:0] LOV   = 16'h0004;

  logic clk = 1'b0;
  logic rst_n, por_n, hi_n, lo_n, bnd, iret;
  logic run, take, poll_n, isr_hi, isr_lo;
  logic [15:0] vec;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  prio_irq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .por_ni(por_n), .irq_hi_ni(hi_n), .irq_lo_ni(lo_n),
    .boundary_i(bnd), .iret_i(iret), .run_o(run), .take_o(take), .vec_o(vec),
    .poll_no(poll_n), .isr_hi_o(isr_hi), .isr_lo_o(isr_lo)
  );

  // row: {hi_n, lo_n, bnd, iret, exp_hi, exp_lo}
  localparam logic [5:0] TBL [15] = '{
    6'b101_0_01, // R6 low granted from idle
    6'b001_0_11, // R7 high preempts low
    6'b110_1_01, // R9 return ends high, low resumes
    6'b110_1_00, // R9 return ends low
    6'b011_0_10, // R5 high granted
    6'b001_0_10, // R8 low cannot preempt high
    6'b100_1_00, // R9 return ends high
    6'b101_0_01, // R6 waiting low granted once idle
    6'b000_0_01, // R4 no boundary, no grant
    6'b001_0_11, // R7 high preempts at boundary
    6'b110_1_01, // R9
    6'b110_1_00, // R9
    6'b001_0_10, // R8 simultaneous, high wins
    6'b110_1_00, // R9
    6'b110_1_00  // R10 return with nothing in service
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int ntake;
    rst_n = 0; por_n = 1; hi_n = 1; lo_n = 1; bnd = 0; iret = 0;
    cyc(3);
    chk("R1 reset run/take/poll/isr", {run, take, poll_n, isr_hi, isr_lo}, 5'b00100);
    rst_n = 1;
    cyc(2);
    chk("R3 no start before third edge", take, 1'b0);
    cyc(1);
    chk("R3 start pulse take/run/poll", {take, run, poll_n}, 3'b111);
    chk("R3 start address", vec, START);
    cyc(1);
    chk("R3 start pulse one cycle", take, 1'b0);

    for (int i = 0; i < 15; i++) begin
      hi_n = TBL[i][5]; lo_n = TBL[i][4]; bnd = TBL[i][3]; iret = TBL[i][2];
      cyc(1);
      iret = 0;
      cyc(3);
      chk($sformatf("R6-9 table row %0d isr", i), {isr_hi, isr_lo}, TBL[i][1:0]);
    end
    hi_n = 1; lo_n = 1; bnd = 0; cyc(4);

    // R4/R5 grant timing and poll strobe
    hi_n = 0; bnd = 1;
    cyc(2);
    chk("R4 no take before third edge", take, 1'b0);
    cyc(1);
    chk("R5 high take/poll", {take, poll_n}, 2'b10);
    chk("R5 high vector", vec, HIV);
    cyc(1);
    chk("R5 take and poll one cycle", {take, poll_n, isr_hi}, 3'b011);
    hi_n = 1; bnd = 0; iret = 1; cyc(1); iret = 0; cyc(3);

    // R6 low vector
    lo_n = 0; bnd = 1; cyc(3);
    chk("R6 low take/poll", {take, poll_n}, 2'b10);
    chk("R6 low vector", vec, LOV);
    lo_n = 1; bnd = 0; iret = 1; cyc(1); iret = 0; cyc(3);
    chk("R9 low closed", {isr_hi, isr_lo}, 2'b00);

    // R4 request without boundary ignored
    hi_n = 0; bnd = 0; ntake = 0;
    for (int k = 0; k < 6; k++) begin cyc(1); ntake += take; end
    chk("R4 no boundary no take", ntake, 0);
    chk("R4 no boundary isr", {isr_hi, isr_lo}, 2'b00);
    // R10 return during boundary suppresses grant
    bnd = 1; iret = 1; cyc(1);
    bnd = 0; iret = 0; cyc(2);
    chk("R10 grant suppressed by return", {isr_hi, take}, 2'b00);
    hi_n = 1; cyc(3);

    // R2 preset during service
    hi_n = 0; bnd = 1; cyc(4);
    chk("R2 setup high in service", isr_hi, 1'b1);
    hi_n = 1; bnd = 0; cyc(3);
    por_n = 0;
    cyc(3);
    chk("R2 preset halts and clears", {run, isr_hi, isr_lo}, 3'b000);
    hi_n = 0; lo_n = 0; bnd = 1; ntake = 0;
    for (int k = 0; k < 6; k++) begin cyc(1); ntake += take; end
    chk("R2 no take while preset held", ntake, 0);
    chk("R2 isr clear while preset held", {isr_hi, isr_lo}, 2'b00);
    hi_n = 1; lo_n = 1; bnd = 0; cyc(3);
    por_n = 1;
    cyc(3);
    chk("R3 restart take/run/poll", {take, run, poll_n}, 3'b111);
    chk("R3 restart address", vec, START);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule